// File: doc/BRIEF.md
# USB Bus Activity Detector

This block watches the decoded line state of a full-speed USB receiver and keeps one internal level, `busActive`, that shows whether the bus carries traffic. A pulse from the SYNC detector sets the level. A run of consecutive idle (J state) bit times clears it. While a USB bus reset is in progress the level is forced low.

Each idle-to-active transition latches an interrupt request bit. The CPU reaches the request bit and an enable bit through a small register port. The request is cleared by writing a 1 to it. The interrupt output is the request gated by the enable.

Power-on reset, a synchronous chip reset and a bus reset all clear the request and the enable. Line decoding, SYNC detection and suspend handling live outside this block.

Top module: `usb_activity_monitor`

## Requirements
- R1: A `syncSeen` pulse with no bus reset and no chip reset active makes `busActive` read 1 on the next cycle.
- R2: `busActive` goes to 0 on the cycle after the 32nd consecutive `bitStrobe` that samples `lineJ`=1 with no SYNC in between. A strobe with `lineJ`=0 restarts the count, and so does a SYNC. Cycles without a strobe neither count nor restart.
- R3: While `busReset` is 1, `busActive` is 0 on the next cycle, and a SYNC in that cycle is ignored.
- R4: The request bit is set only when `busActive` changes from 0 to 1. A SYNC that arrives while the bus is already active leaves the request as it is.
- R5: A write with `regSel`=0 and `regWdata` bit 0 = 1 clears the request. A write with that bit at 0 has no effect.
- R6: After power-on reset (`rstN`=0), `chipReset` or `busReset`, both the request and the enable read 0.
- R7: `irqOut` equals request AND enable. Clearing the enable (write with `regSel`=1, bit 0 = 0) does not clear the latched request.
- R8: If a request set event and a CPU clear of the request occur in the same cycle, the request ends up set.
- R9: `regRdata` shows the request in bit 0 when `regSel`=0 and the enable in bit 0 when `regSel`=1. All other bits read 0.
- R10: The idle count saturates. Further J strobes on an idle bus keep `busActive` at 0 and set no request, and a later SYNC starts a new active period with a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| chipReset | input | 1 | Synchronous chip reset |
| syncSeen | input | 1 | One-cycle pulse: SYNC field received |
| lineJ | input | 1 | Line is in J state |
| bitStrobe | input | 1 | One-cycle pulse per bit time |
| busReset | input | 1 | USB bus reset in progress |
| regWrite | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = request register, 1 = enable register |
| regWdata | input | 8 | Write data, bit 0 used |
| regRdata | output | 8 | Read data of the selected register |
| busActive | output | 1 | Internal bus-active level |
| irqOut | output | 1 | Request AND enable |

## Verification
Directed runs of exactly 31 and then 32 J strobes separate an off-by-one idle threshold from a correct one. A non-J strobe placed mid-run and gaps with no strobe show whether the count restarts or pauses. A SYNC sent to a bus that is already active, and one sent to an idle bus, separate edge-triggered from level-triggered setting of the request. A SYNC that coincides with a bus reset, and a clear write that coincides with a set event, check the priorities. Long random stretches mix sparse SYNCs, gapped strobes, J/K levels, rare resets and register writes, with every cycle compared against a bench model.

// File: rtl/usb_act_pkg.sv
package usb_act_pkg;

  typedef struct packed {
    logic restartIdle;
    logic countIdle;
    logic setActive;
    logic clearActive;
    logic setReq;
    logic clearReq;
    logic loadEnable;
    logic clearRegs;
  } actStrobes_t;

endpackage

// File: rtl/usb_act_ctrl.sv
module usb_act_ctrl
  import usb_act_pkg::*;
(
  input  logic        syncSeen,
  input  logic        lineJ,
  input  logic        bitStrobe,
  input  logic        busReset,
  input  logic        chipReset,
  input  logic        regWrite,
  input  logic        regSel,
  input  logic        wdataBit,
  input  logic        activeQ,
  input  logic        idleLast,
  output actStrobes_t strb
);

  logic anyReset;
  logic restart;
  logic count;

  always_comb begin
    anyReset = chipReset | busReset;
    restart  = anyReset | syncSeen | (bitStrobe & ~lineJ);
    count    = ~restart & bitStrobe & lineJ;

    strb.clearRegs   = anyReset;
    strb.restartIdle = restart;
    strb.countIdle   = count;
    strb.setActive   = ~anyReset & syncSeen;
    strb.clearActive = anyReset | (count & idleLast);
    // rising edge of the activity level: set while currently low
    strb.setReq      = ~anyReset & syncSeen & ~activeQ;
    strb.clearReq    = regWrite & ~regSel & wdataBit;
    strb.loadEnable  = regWrite & regSel;
  end

endmodule

// File: rtl/usb_act_dp.sv
module usb_act_dp
  import usb_act_pkg::*;
#(
  parameter int IDLE_LIMIT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  actStrobes_t strb,
  input  logic        wdataBit,
  output logic        activeQ,
  output logic        reqQ,
  output logic        enQ,
  output logic        idleLast
);

  localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(IDLE_LIMIT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_LIMIT - 1);

  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strb.restartIdle) begin
      idleCnt <= '0;
    end else if (strb.countIdle && idleCnt != CNT_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign idleLast = (idleCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
    end else if (strb.clearActive) begin
      activeQ <= 1'b0;
    end else if (strb.setActive) begin
      activeQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
    end else if (strb.clearRegs) begin
      reqQ <= 1'b0;
    end else if (strb.setReq) begin
      reqQ <= 1'b1;
    end else if (strb.clearReq) begin
      reqQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0;
    end else if (strb.clearRegs) begin
      enQ <= 1'b0;
    end else if (strb.loadEnable) begin
      enQ <= wdataBit;
    end
  end

  // the idle count never runs past its saturation value
  assert_idle_sat_R10: assert property (@(posedge clk) disable iff (!rstN)
    idleCnt <= CNT_MAX);

  // a saturated count on a quiet line keeps the bus inactive
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt == CNT_MAX && !strb.setActive) |=> !activeQ);

endmodule

// File: rtl/usb_activity_monitor.sv
module usb_activity_monitor
  import usb_act_pkg::*;
#(
  parameter int IDLE_LIMIT = 32,
  parameter int DATA_W     = 8,
  parameter int FLAG_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipReset,
  input  logic              syncSeen,
  input  logic              lineJ,
  input  logic              bitStrobe,
  input  logic              busReset,
  input  logic              regWrite,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              busActive,
  output logic              irqOut
);

  actStrobes_t strb;
  logic activeQ;
  logic reqQ;
  logic enQ;
  logic idleLast;

  usb_act_ctrl u_ctrl (
    .syncSeen  (syncSeen),
    .lineJ     (lineJ),
    .bitStrobe (bitStrobe),
    .busReset  (busReset),
    .chipReset (chipReset),
    .regWrite  (regWrite),
    .regSel    (regSel),
    .wdataBit  (regWdata[FLAG_BIT]),
    .activeQ   (activeQ),
    .idleLast  (idleLast),
    .strb      (strb)
  );

  usb_act_dp #(.IDLE_LIMIT(IDLE_LIMIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wdataBit (regWdata[FLAG_BIT]),
    .activeQ  (activeQ),
    .reqQ     (reqQ),
    .enQ      (enQ),
    .idleLast (idleLast)
  );

  always_comb begin
    regRdata           = '0;
    regRdata[FLAG_BIT] = regSel ? enQ : reqQ;
  end

  assign busActive = activeQ;
  assign irqOut    = reqQ & enQ;

  assert_sync_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    (syncSeen && !busReset && !chipReset) |=> busActive);

  assert_busrst_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!busActive && !reqQ));

  assert_req_on_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqQ) |-> $rose(busActive));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && !regSel && regWdata[FLAG_BIT] && !syncSeen) |=> !reqQ);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (syncSeen && !busActive && !busReset && !chipReset) |=> reqQ);

  assert_resets_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    chipReset |=> (!reqQ && !enQ && !busActive));

endmodule

// File: tb/usb_activity_monitor_bench.sv
module usb_activity_monitor_bench;

  localparam int LIMIT = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipReset = 1'b0;
  logic       syncSeen = 1'b0;
  logic       lineJ = 1'b1;
  logic       bitStrobe = 1'b0;
  logic       busReset = 1'b0;
  logic       regWrite = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       busActive;
  logic       irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  logic mAct = 0, mReq = 0, mEn = 0;
  int   mCnt = 0;

  always #4 clk = ~clk;

  usb_activity_monitor u_usb_activity_monitor (
    .clk(clk), .rstN(rstN), .chipReset(chipReset), .syncSeen(syncSeen),
    .lineJ(lineJ), .bitStrobe(bitStrobe), .busReset(busReset),
    .regWrite(regWrite), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .busActive(busActive), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead();
    return {7'b0, (regSel ? mEn : mReq)};
  endfunction

  // bench model, stepped with the inputs applied in the last cycle
  task automatic modelStep();
    logic rst = chipReset | busReset;
    logic rise = !rst && syncSeen && !mAct;
    if (rst) begin
      mAct = 0; mCnt = 0;
    end else if (syncSeen) begin
      mAct = 1; mCnt = 0;
    end else if (bitStrobe) begin
      if (!lineJ) mCnt = 0;
      else if (mCnt < LIMIT) begin
        mCnt++;
        if (mCnt == LIMIT) mAct = 0;
      end
    end
    if (rst) mReq = 0;
    else if (rise) mReq = 1;
    else if (regWrite && !regSel && regWdata[0]) mReq = 0;
    if (rst) mEn = 0;
    else if (regWrite && regSel) mEn = regWdata[0];
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    cycles++;
    modelStep();
    check(busActive === mAct, tag, "busActive", busActive, mAct);
    check(irqOut === (mReq & mEn), "R7", "irqOut", irqOut, mReq & mEn);
    check(regRdata === expRead(), "R9", "regRdata", regRdata, expRead());
    syncSeen = 0; regWrite = 0; chipReset = 0; bitStrobe = 0;
  endtask

  task automatic jStrobes(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      lineJ = 1; bitStrobe = 1; step(tag);
      step(tag);  // gap cycle without strobe
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d, input string tag);
    regWrite = 1; regSel = sel; regWdata = d; step(tag);
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      if (cycles > 100000 || $time > 64'd1600000) begin
        testsRun++; testsFailed++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R6: power-on reset state
    check(busActive === 0, "R6", "reset busActive", busActive, 0);
    check(irqOut === 0, "R6", "reset irqOut", irqOut, 0);
    regSel = 1;
    #1 check(regRdata === 8'h00, "R6", "reset enable", regRdata, 0);
    regSel = 0;
    #1 check(regRdata === 8'h00, "R6", "reset request", regRdata, 0);

    // R9: enable read back; other bits zero
    wr(1, 8'hFF, "R9");
    check(regRdata === 8'h01, "R9", "enable readback", regRdata, 1);
    regSel = 0;

    // R1/R4: sync on idle bus sets activity and request
    syncSeen = 1; step("R1");
    check(busActive === 1, "R1", "active after sync", busActive, 1);
    check(irqOut === 1, "R4", "irq after rise", irqOut, 1);

    // R5: write 0 has no effect, write 1 clears
    wr(0, 8'hFE, "R5");
    check(regRdata === 8'h01, "R5", "write0 keeps request", regRdata, 1);
    wr(0, 8'h01, "R5");
    check(regRdata === 8'h00, "R5", "write1 clears request", regRdata, 0);

    // R4: sync while active does not set the request
    syncSeen = 1; step("R4");
    check(regRdata === 8'h00, "R4", "no request when already active", regRdata, 0);

    // R2: 31 J strobes keep active; a K strobe restarts the count
    jStrobes(31, "R2");
    check(busActive === 1, "R2", "active after 31 J", busActive, 1);
    lineJ = 0; bitStrobe = 1; step("R2");
    jStrobes(31, "R2");
    check(busActive === 1, "R2", "active after K then 31 J", busActive, 1);
    jStrobes(1, "R2");
    check(busActive === 0, "R2", "inactive after 32 J", busActive, 0);

    // R10: saturation, no new request, then a fresh sync rises again
    jStrobes(40, "R10");
    check(busActive === 0 && regRdata === 8'h00, "R10", "idle stays quiet",
          {busActive, regRdata[0]}, 0);
    syncSeen = 1; step("R10");
    check(busActive === 1 && regRdata === 8'h01, "R10", "new rise sets request",
          {busActive, regRdata[0]}, 3);

    // R7: disabling does not clear the request
    wr(1, 8'h00, "R7");
    check(irqOut === 0, "R7", "irq gated off", irqOut, 0);
    regSel = 0; #1;
    check(regRdata === 8'h01, "R7", "request kept", regRdata, 1);

    // R3: bus reset holds the bus inactive, sync ignored; R6 clears regs
    wr(1, 8'h01, "R3");
    busReset = 1; syncSeen = 1; step("R3");
    check(busActive === 0, "R3", "busreset forces idle", busActive, 0);
    syncSeen = 1; step("R3");
    check(busActive === 0, "R3", "sync ignored in busreset", busActive, 0);
    check(irqOut === 0, "R6", "busreset clears", irqOut, 0);
    busReset = 0; step("R3");

    // R8: set and clear together, set wins
    jStrobes(33, "R8");
    syncSeen = 1; regWrite = 1; regSel = 0; regWdata = 8'h01; step("R8");
    check(regRdata === 8'h01, "R8", "set wins over clear", regRdata, 1);

    // R6: chip reset clears request and enable
    wr(1, 8'h01, "R6");
    chipReset = 1; step("R6");
    check(irqOut === 0 && busActive === 0, "R6", "chip reset clears",
          {irqOut, busActive}, 0);

    // random stretch compared against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      syncSeen  = ($urandom_range(0, 59) == 0);
      bitStrobe = ($urandom_range(0, 2) != 0);
      lineJ     = ($urandom_range(0, 15) != 0);
      busReset  = ($urandom_range(0, 299) == 0) ? ~busReset : busReset;
      if (busReset && $urandom_range(0, 3) == 0) busReset = 0;
      chipReset = ($urandom_range(0, 999) == 0);
      regWrite  = ($urandom_range(0, 19) == 0);
      regSel    = $urandom_range(0, 1);
      regWdata  = 8'($urandom);
      step("R2");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule